// File: doc/BRIEF.md
# TDM Channel Time-Slot Assigner

The block places two byte-wide bearer channels (B1, B2) and one two-bit signalling channel on a serial time-division highway. The highway frame has 64 slots of 8 bits each, giving 512 bit times. A single bit clock drives all timing, and a frame-sync input marks where each frame begins. In the transmit direction the block picks the assigned bytes and the assigned bit pair out of the serial input. It hands each one to the line side as a parallel word with a one-cycle strobe. In the receive direction it takes parallel words from the line side and shifts them onto the serial output at the assigned positions. A drive-enable tells the pad when the output is actually driven, so the pad can go high-impedance otherwise.

Software programs six slot-assignment registers through a write port. Writes go to a pending copy. The copy that steers the datapath is loaded only at a frame boundary. The receive-side parallel data is also sampled at that boundary, so every frame is built from one consistent snapshot.

Frame timing is kept by a two-state machine. **HUNT** is the state after reset: the bit counter is idle and the output is not driven. **RUN** is the aligned state. The transitions are:
- HUNT → RUN when a sync pulse is seen.
- RUN → RUN with realignment when a sync pulse is seen. The counter restarts at position 0.
- RUN → RUN by free-running wrap when position 511 passes without a sync pulse.

Both the sync pulse and the wrap count as a frame boundary.

Top module: `tdm_slot_mapper`

## Requirements
- R1: Reset values of the assignment registers are:

  | Register | Reset value | Meaning |
  |---|---|---|
  | transmit B1 | 0 | slot 0 |
  | transmit B2 | 1 | slot 1 |
  | receive B1 | 0x00 | slot 0, disabled |
  | receive B2 | 0x01 | slot 1, disabled |
  | transmit signalling | 0x08 | slot 2, sub-slot 0 |
  | receive signalling | 0x08 | slot 2, sub-slot 0 |

  With these values, the first frame captures slots 0, 1 and bits 0–1 of slot 2, and the output is never driven.
- R2: Position 0 is slot 0, bit 0. A sync sampled high at a rising edge makes that edge position 0 and enters RUN. With no sync, position 511 is followed by position 0. The position counts slot×8 + bit, and bit 0 of a slot is its most significant bit.
- R3: In HUNT, before the first sync, `ser_oe` is 0 and no transmit strobe occurs.
- R4: A transmit B channel collects the 8 bits of its assigned slot, most significant bit first. After the rising edge that starts the position following the slot's last bit, its data port shows the byte and its valid strobe is high for exactly one cycle.
- R5: Sub-slot s covers bits 2s and 2s+1 of the transmit signalling slot. After the second of these bits, `tx_d_data` = {bit 2s, bit 2s+1} and `tx_d_vld` pulses for one cycle.
- R6: An enabled receive B channel drives `ser_out` with its held byte during its slot, most significant bit first, with `ser_oe` = 1. At positions that no enabled channel claims, `ser_oe` is 0.
- R7: Receive signalling bit 2s carries `rx_d_data[1]` and bit 2s+1 carries `rx_d_data[0]`, in its assigned sub-slot. It is driven only while the enable bit (bit 6 of the receive B1 register) is set.
- R8: When enabled receive channels claim the same position, B1 wins over B2, and B2 wins over signalling.
- R9: Register writes and changes on the receive parallel data ports affect the highway only from the next frame boundary onward.
- R10: `ser_in` is sampled on the falling clock edge. `ser_out` and `ser_oe` change only after a rising edge.
- R11: The register addresses and field layouts are:

  | Address | Register | Bits 7 | Bit 6 | Bits 5:0 | Bits 1:0 |
  |---|---|---|---|---|---|
  | 0 | transmit B1 | — | — | slot | — |
  | 1 | transmit B2 | — | — | slot | — |
  | 2 | receive B1 | B1 enable | signalling enable | slot | — |
  | 3 | receive B2 | B2 enable | — | slot | — |
  | 4 | transmit signalling | slot in bits 7:2 | | | sub-slot |
  | 5 | receive signalling | slot in bits 7:2 | | | sub-slot |

  Writes to addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame-sync pulse, sampled on the rising edge |
| ser_in | input | 1 | Serial highway input (transmit direction) |
| ser_out | output | 1 | Serial highway output (receive direction) |
| ser_oe | output | 1 | Drive enable for `ser_out`; 0 means high-impedance |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| tx_b1_data | output | 8 | Captured B1 byte |
| tx_b1_vld | output | 1 | One-cycle strobe for `tx_b1_data` |
| tx_b2_data | output | 8 | Captured B2 byte |
| tx_b2_vld | output | 1 | One-cycle strobe for `tx_b2_data` |
| tx_d_data | output | 2 | Captured signalling bit pair |
| tx_d_vld | output | 1 | One-cycle strobe for `tx_d_data` |
| rx_b1_data | input | 8 | B1 byte to place on the highway |
| rx_b2_data | input | 8 | B2 byte to place on the highway |
| rx_d_data | input | 2 | Signalling pair to place on the highway |

## Verification
Some properties are checked on every cycle:
- A sync pulse always lands the machine in RUN at position 0.
- The active configuration never moves except at a frame boundary.
- Every transmit strobe lasts a single cycle.
- The output is never driven in HUNT or with every receive channel disabled.

The bench scenarios cover what those properties cannot. They check the exact byte and bit-pair values taken from chosen slots and sub-slots, including slot 63 with sub-slot 3. They check the serial pattern produced for random configurations, the priority among overlapping receive channels, and that mid-frame writes and data changes stay invisible until the next boundary, whether that boundary comes from sync or from wrap.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    localparam int SLOT_W  = 6;
    localparam int BIT_W   = 3;
    localparam int CNT_W   = SLOT_W + BIT_W;
    localparam int BYTE_W  = 1 << BIT_W;
    localparam int SIG_W   = 2;
    localparam int SUB_W   = BIT_W - 1;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_B   = 2;

    localparam logic [ADDR_W-1:0] A_TX_B1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TX_B2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RX_B1  = 3'd2;
    localparam logic [ADDR_W-1:0] A_RX_B2  = 3'd3;
    localparam logic [ADDR_W-1:0] A_TX_SIG = 3'd4;
    localparam logic [ADDR_W-1:0] A_RX_SIG = 3'd5;

    typedef enum logic {ST_HUNT, ST_RUN} frame_state_t;

    typedef struct packed {
        logic [NUM_B-1:0][SLOT_W-1:0] tx_b_slot;
        logic [NUM_B-1:0][SLOT_W-1:0] rx_b_slot;
        logic [NUM_B-1:0]             rx_b_en;
        logic [SLOT_W-1:0]            tx_sig_slot;
        logic [SUB_W-1:0]             tx_sig_sub;
        logic [SLOT_W-1:0]            rx_sig_slot;
        logic [SUB_W-1:0]             rx_sig_sub;
        logic                         rx_sig_en;
    } tsa_cfg_t;

    function automatic tsa_cfg_t cfg_reset();
        tsa_cfg_t c;
        c = '0;
        c.tx_b_slot[1] = SLOT_W'(1);
        c.rx_b_slot[1] = SLOT_W'(1);
        c.tx_sig_slot  = SLOT_W'(2);
        c.rx_sig_slot  = SLOT_W'(2);
        return c;
    endfunction
endpackage

// File: rtl/tsa_frame_fsm.sv
module tsa_frame_fsm
    import tsa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output frame_state_t     state,
    output logic [CNT_W-1:0] pos,
    output logic             boundary
);
    localparam logic [CNT_W-1:0] LAST_POS = '1;

    frame_state_t     state_nxt;
    logic [CNT_W-1:0] pos_nxt;

    // next-state and output decode
    always_comb begin
        state_nxt = state;
        pos_nxt   = pos;
        boundary  = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (fsync) begin
                    state_nxt = ST_RUN;
                    pos_nxt   = '0;
                    boundary  = 1'b1;
                end
            end
            ST_RUN: begin
                boundary = fsync || (pos == LAST_POS);
                pos_nxt  = fsync ? '0 : pos + 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            pos   <= '0;
        end else begin
            state <= state_nxt;
            pos   <= pos_nxt;
        end
    end

    // R2: a sync pulse always restarts the frame at position 0 in RUN
    p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (state == ST_RUN && pos == '0));
endmodule

// File: rtl/tsa_cfg_regs.sv
module tsa_cfg_regs
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              boundary,
    output tsa_cfg_t          active
);
    tsa_cfg_t pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= cfg_reset();
        end else if (we) begin
            case (addr)
                A_TX_B1:  pending.tx_b_slot[0] <= wdata[SLOT_W-1:0];
                A_TX_B2:  pending.tx_b_slot[1] <= wdata[SLOT_W-1:0];
                A_RX_B1: begin
                    pending.rx_b_slot[0] <= wdata[SLOT_W-1:0];
                    pending.rx_b_en[0]   <= wdata[REG_W-1];
                    pending.rx_sig_en    <= wdata[REG_W-2];
                end
                A_RX_B2: begin
                    pending.rx_b_slot[1] <= wdata[SLOT_W-1:0];
                    pending.rx_b_en[1]   <= wdata[REG_W-1];
                end
                A_TX_SIG: begin
                    pending.tx_sig_slot <= wdata[REG_W-1:SUB_W];
                    pending.tx_sig_sub  <= wdata[SUB_W-1:0];
                end
                A_RX_SIG: begin
                    pending.rx_sig_slot <= wdata[REG_W-1:SUB_W];
                    pending.rx_sig_sub  <= wdata[SUB_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // shadow copy steering the datapath, loaded only at a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        active <= cfg_reset();
        else if (boundary) active <= pending;
    end

    // R9: configuration seen by the datapath changes only at a boundary
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active));
endmodule

// File: rtl/tsa_tx_capture.sv
module tsa_tx_capture
    import tsa_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ser_in,
    input  logic                           run,
    input  logic [CNT_W-1:0]               pos,
    input  logic [NUM_B-1:0][SLOT_W-1:0]   tx_b_slot,
    input  logic [SLOT_W-1:0]              tx_sig_slot,
    input  logic [SUB_W-1:0]               tx_sig_sub,
    output logic [NUM_B-1:0][BYTE_W-1:0]   b_data,
    output logic [NUM_B-1:0]               b_vld,
    output logic [SIG_W-1:0]               sig_data,
    output logic                           sig_vld
);
    logic             cap_bit;
    logic             cap_ok;
    logic [CNT_W-1:0] cap_pos;
    logic [SLOT_W-1:0] cap_slot;
    logic [BIT_W-1:0]  cap_idx;

    // R10: the line is sampled on the falling edge, tagged with its position
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_bit <= 1'b0;
            cap_ok  <= 1'b0;
            cap_pos <= '0;
        end else begin
            cap_bit <= ser_in;
            cap_ok  <= run;
            cap_pos <= pos;
        end
    end

    assign cap_slot = cap_pos[CNT_W-1:BIT_W];
    assign cap_idx  = cap_pos[BIT_W-1:0];

    for (genvar g = 0; g < NUM_B; g++) begin : g_bch
        logic [BYTE_W-2:0] sr;
        logic [BYTE_W-1:0] data_q;
        logic              vld_q;
        logic              hit;
        assign hit = cap_ok && (cap_slot == tx_b_slot[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr     <= '0;
                data_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= 1'b0;
                if (hit) begin
                    sr <= {sr[BYTE_W-3:0], cap_bit};
                    if (cap_idx == '1) begin
                        data_q <= {sr, cap_bit};
                        vld_q  <= 1'b1;
                    end
                end
            end
        end
        assign b_data[g] = data_q;
        assign b_vld[g]  = vld_q;

        // R4: each byte strobe lasts one cycle
        p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q |=> !vld_q);
    end

    // signalling pair: first bit on even index, second on odd index
    logic sig_first;
    logic sig_hit;
    assign sig_hit = cap_ok && (cap_slot == tx_sig_slot)
                     && (cap_idx[BIT_W-1:1] == tx_sig_sub);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_first <= 1'b0;
            sig_data  <= '0;
            sig_vld   <= 1'b0;
        end else begin
            sig_vld <= 1'b0;
            if (sig_hit) begin
                if (!cap_idx[0]) begin
                    sig_first <= cap_bit;
                end else begin
                    sig_data <= {sig_first, cap_bit};
                    sig_vld  <= 1'b1;
                end
            end
        end
    end

    // R5: the pair strobe lasts one cycle
    p_sig_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sig_vld |=> !sig_vld);
endmodule

// File: rtl/tsa_rx_driver.sv
module tsa_rx_driver
    import tsa_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic                           boundary,
    input  logic [CNT_W-1:0]               pos,
    input  logic [NUM_B-1:0][SLOT_W-1:0]   rx_b_slot,
    input  logic [NUM_B-1:0]               rx_b_en,
    input  logic [SLOT_W-1:0]              rx_sig_slot,
    input  logic [SUB_W-1:0]               rx_sig_sub,
    input  logic                           rx_sig_en,
    input  logic [NUM_B-1:0][BYTE_W-1:0]   rx_b_data,
    input  logic [SIG_W-1:0]               rx_sig_data,
    output logic                           ser_out,
    output logic                           ser_oe
);
    logic [NUM_B-1:0][BYTE_W-1:0] hold_b;
    logic [SIG_W-1:0]             hold_sig;

    // frame snapshot of the line-side data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_b   <= '0;
            hold_sig <= '0;
        end else if (boundary) begin
            hold_b   <= rx_b_data;
            hold_sig <= rx_sig_data;
        end
    end

    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  idx;
    assign slot = pos[CNT_W-1:BIT_W];
    assign idx  = pos[BIT_W-1:0];

    logic [NUM_B-1:0] hit_b;
    logic [NUM_B-1:0] bit_b;
    for (genvar g = 0; g < NUM_B; g++) begin : g_bsel
        assign hit_b[g] = run && rx_b_en[g] && (slot == rx_b_slot[g]);
        assign bit_b[g] = hold_b[g][~idx];
    end

    logic hit_sig;
    assign hit_sig = run && rx_sig_en && (slot == rx_sig_slot)
                     && (idx[BIT_W-1:1] == rx_sig_sub);

    // fixed priority: B1, then B2, then signalling
    always_comb begin
        ser_oe  = 1'b0;
        ser_out = 1'b0;
        if (hit_b[0]) begin
            ser_oe  = 1'b1;
            ser_out = bit_b[0];
        end else if (hit_b[1]) begin
            ser_oe  = 1'b1;
            ser_out = bit_b[1];
        end else if (hit_sig) begin
            ser_oe  = 1'b1;
            ser_out = hold_sig[~idx[0]];
        end
    end

    // R3: nothing is driven until the frame is aligned
    p_hiz_hunt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ser_oe);

    // R6: the pad is driven only when some receive channel is enabled
    p_oe_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_oe |-> (rx_b_en != '0 || rx_sig_en));
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
    import tsa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fsync,
    input  logic        ser_in,
    output logic        ser_out,
    output logic        ser_oe,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  tx_b1_data,
    output logic        tx_b1_vld,
    output logic [7:0]  tx_b2_data,
    output logic        tx_b2_vld,
    output logic [1:0]  tx_d_data,
    output logic        tx_d_vld,
    input  logic [7:0]  rx_b1_data,
    input  logic [7:0]  rx_b2_data,
    input  logic [1:0]  rx_d_data
);
    frame_state_t                 state;
    logic [CNT_W-1:0]             pos;
    logic                         boundary;
    logic                         run;
    tsa_cfg_t                     cfg;
    logic [NUM_B-1:0][BYTE_W-1:0] tx_b_data;
    logic [NUM_B-1:0]             tx_b_vld;

    assign run = (state == ST_RUN);

    tsa_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .state    (state),
        .pos      (pos),
        .boundary (boundary)
    );

    tsa_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .boundary (boundary),
        .active   (cfg)
    );

    tsa_tx_capture u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .run         (run),
        .pos         (pos),
        .tx_b_slot   (cfg.tx_b_slot),
        .tx_sig_slot (cfg.tx_sig_slot),
        .tx_sig_sub  (cfg.tx_sig_sub),
        .b_data      (tx_b_data),
        .b_vld       (tx_b_vld),
        .sig_data    (tx_d_data),
        .sig_vld     (tx_d_vld)
    );

    tsa_rx_driver u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .boundary    (boundary),
        .pos         (pos),
        .rx_b_slot   (cfg.rx_b_slot),
        .rx_b_en     (cfg.rx_b_en),
        .rx_sig_slot (cfg.rx_sig_slot),
        .rx_sig_sub  (cfg.rx_sig_sub),
        .rx_sig_en   (cfg.rx_sig_en),
        .rx_b_data   ({rx_b2_data, rx_b1_data}),
        .rx_sig_data (rx_d_data),
        .ser_out     (ser_out),
        .ser_oe      (ser_oe)
    );

    assign tx_b1_data = tx_b_data[0];
    assign tx_b1_vld  = tx_b_vld[0];
    assign tx_b2_data = tx_b_data[1];
    assign tx_b2_vld  = tx_b_vld[1];
endmodule

// File: tb/test_tdm_slot_mapper.sv
`timescale 1ns/1ps
module test_tdm_slot_mapper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       ser_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rx_b1_data = '0;
    logic [7:0] rx_b2_data = '0;
    logic [1:0] rx_d_data = '0;
    logic       ser_out, ser_oe;
    logic [7:0] tx_b1_data, tx_b2_data;
    logic       tx_b1_vld, tx_b2_vld, tx_d_vld;
    logic [1:0] tx_d_data;

    tdm_slot_mapper i_tdm_slot_mapper (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .tx_b1_data(tx_b1_data), .tx_b1_vld(tx_b1_vld),
        .tx_b2_data(tx_b2_data), .tx_b2_vld(tx_b2_vld),
        .tx_d_data(tx_d_data), .tx_d_vld(tx_d_vld),
        .rx_b1_data(rx_b1_data), .rx_b2_data(rx_b2_data), .rx_d_data(rx_d_data)
    );

    always #2 clk = ~clk;

    localparam int NF = 24;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 1'b0;

    // active (c_) and pending (n_) configuration as the bench predicts it
    int c_tb1 = 0, c_tb2 = 1, c_rb1 = 0, c_rb2 = 1, c_td = 2, c_tds = 0, c_rd = 2, c_rds = 0;
    bit c_eb1 = 0, c_eb2 = 0, c_ed = 0;
    int n_tb1 = 0, n_tb2 = 1, n_rb1 = 0, n_rb2 = 1, n_td = 2, n_tds = 0, n_rd = 2, n_rds = 0;
    bit n_eb1 = 0, n_eb2 = 0, n_ed = 0;
    logic [7:0] h_b1 = '0, h_b2 = '0;
    logic [1:0] h_d = '0;

    bit fin [0:511];
    bit         e_b1v = 0, e_b2v = 0, e_dv = 0;
    logic [7:0] e_b1d = '0, e_b2d = '0;
    logic [1:0] e_dd = '0;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int slot);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = fin[slot*8+k];
        return b;
    endfunction

    // expected drive at position p: {oe, bit}; src names the winning channel
    function automatic logic [1:0] exp_drive(input int p, output string src);
        int slot = p / 8;
        int b    = p % 8;
        src = "R6";
        if (c_eb1 && slot == c_rb1) begin src = "R8"; return {1'b1, h_b1[7-b]}; end
        if (c_eb2 && slot == c_rb2) begin src = "R8"; return {1'b1, h_b2[7-b]}; end
        if (c_ed && slot == c_rd && (b / 2) == c_rds) begin
            src = "R7";
            return {1'b1, (b % 2 == 0) ? h_d[1] : h_d[0]};
        end
        return 2'b00;
    endfunction

    // choose the configuration written during frame f (active from frame f+1)
    task automatic plan_cfg(input int f);
        n_tb1 = $urandom % 64; n_tb2 = $urandom % 64;
        n_rb1 = $urandom % 64; n_rb2 = $urandom % 64;
        n_td  = $urandom % 64; n_tds = $urandom % 4;
        n_rd  = $urandom % 64; n_rds = $urandom % 4;
        n_eb1 = ($urandom % 4) != 0; n_eb2 = ($urandom % 4) != 0; n_ed = ($urandom % 4) != 0;
        if (f == 0) begin
            n_rb1 = 5; n_rb2 = 5; n_rd = 5; n_eb1 = 1; n_eb2 = 1; n_ed = 1;
        end else if (f == 1) begin
            n_eb1 = 0; n_rb2 = 9; n_rd = 9; n_rds = 1; n_eb2 = 1; n_ed = 1;
        end else if (f == 2) begin
            n_tb2 = 63; n_td = 63; n_tds = 3; n_rb2 = 63; n_eb2 = 1;
            n_rd = 62; n_rds = 3; n_ed = 1; n_eb1 = 1; n_rb1 = 10;
        end else if (f == 3) begin
            n_tb1 = 0; n_td = 0; n_tds = 0; n_eb1 = 0; n_eb2 = 0;
            n_rd = 0; n_rds = 0; n_ed = 1;
        end
    endtask

    function automatic logic [7:0] wr_value(input int a);
        case (a)
            0: return 8'(n_tb1);
            1: return 8'(n_tb2);
            2: return {n_eb1, n_ed, 6'(n_rb1)};
            3: return {n_eb2, 1'b0, 6'(n_rb2)};
            4: return {6'(n_td), 2'(n_tds)};
            default: return {6'(n_rd), 2'(n_rds)};
        endcase
    endfunction

    initial begin
        bit    next_sync;
        bit    synced;
        string rq;
        string src;
        logic [1:0] ed;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R3", "oe after reset", {7'd0, ser_oe}, 8'd0);

        // HUNT: no sync yet, nothing driven, nothing captured
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1;
            ser_in = 1'($urandom);
            chk("R3", "oe in hunt", {7'd0, ser_oe}, 8'd0);
            chk("R3", "strobes in hunt", {5'd0, tx_b1_vld, tx_b2_vld, tx_d_vld}, 8'd0);
            if (i == 15) fsync = 1'b1;
        end

        synced = 1'b1;
        for (int f = 0; f < NF; f++) begin
            next_sync = (f < 4) ? 1'b1 : (($urandom % 4) != 0);
            for (int p = 0; p < 512; p++) begin
                @(posedge clk); #1;
                if (p == 0) begin
                    c_tb1 = n_tb1; c_tb2 = n_tb2; c_rb1 = n_rb1; c_rb2 = n_rb2;
                    c_td = n_td; c_tds = n_tds; c_rd = n_rd; c_rds = n_rds;
                    c_eb1 = n_eb1; c_eb2 = n_eb2; c_ed = n_ed;
                    h_b1 = rx_b1_data; h_b2 = rx_b2_data; h_d = rx_d_data;
                end
                fsync = (p == 511) && next_sync;

                // strobes for the previous position (R10: falling-edge sample)
                if (f == 0 && p > 0)           rq = "R1";
                else if (!synced)             rq = "R2";
                else if (p > 100 && p < 300)  rq = "R9";
                else                          rq = "R4";
                chk(rq, "b1 vld", {7'd0, tx_b1_vld}, {7'd0, e_b1v});
                if (e_b1v) chk(rq, "b1 byte R10", tx_b1_data, e_b1d);
                chk(rq, "b2 vld", {7'd0, tx_b2_vld}, {7'd0, e_b2v});
                if (e_b2v) chk(rq, "b2 byte", tx_b2_data, e_b2d);
                chk("R5", "d vld", {7'd0, tx_d_vld}, {7'd0, e_dv});
                if (e_dv) chk("R5", "d pair", {6'd0, tx_d_data}, {6'd0, e_dd});

                // new input bit and its expected capture
                ser_in = 1'($urandom);
                fin[p] = ser_in;
                e_b1v = ((p / 8) == c_tb1) && (p % 8 == 7);
                e_b2v = ((p / 8) == c_tb2) && (p % 8 == 7);
                e_dv  = ((p / 8) == c_td) && ((p % 8) == 2 * c_tds + 1);
                if (e_b1v) e_b1d = byte_at(p / 8);
                if (e_b2v) e_b2d = byte_at(p / 8);
                if (e_dv)  e_dd  = {fin[p-1], fin[p]};

                // output drive for this position
                ed = exp_drive(p, src);
                if (f == 0) src = "R1";
                chk(src, "oe", {7'd0, ser_oe}, {7'd0, ed[1]});
                if (ed[1]) chk(src, "ser_out", {7'd0, ser_out}, {7'd0, ed[0]});

                // mid-frame register writes (R9, R11 encodings)
                if (p == 100) plan_cfg(f);
                if (p >= 100 && p <= 105) begin
                    reg_we = 1'b1; reg_addr = 3'(p - 100); reg_wdata = wr_value(p - 100);
                end else if (p == 106) begin
                    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'hFF;
                end else begin
                    reg_we = 1'b0;
                end
                if (p == 200) begin
                    rx_b1_data = 8'($urandom); rx_b2_data = 8'($urandom);
                    rx_d_data  = 2'($urandom);
                end
            end
            synced = next_sync;
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule